// File: doc/BRIEF.md
# Four-Channel Periodic Interrupt Timer Bank

This block holds four independent 32-bit down-counters, each able to raise a periodic interrupt. Software sets a reload value and enables a channel. The channel then counts down by one on every clock. When it passes zero it sets its expiry flag, reloads from the reload register and starts counting again. A reload value of N-1 therefore gives an expiry every N cycles. Each channel's interrupt line is its flag gated by its own interrupt-enable bit.

Writing a new reload value while a channel runs leaves the current period alone; the new value is used from the next reload. To abort a period, software clears the channel's run bit and sets it again, which restarts the count from the reload value. One global halt bit freezes every channel. Channel 1 can be linked to channel 0, so that channel 1 steps once per channel-0 expiry. The pair then acts as a single 64-bit timer.

Access goes through a single-cycle register port. Writes take effect at the clock edge, and the read data is a combinational function of the word address.

Top module: `ptimer_bank`

## Requirements
- R1: After reset, the halt bit reads 1. Every reload, count, control and flag register reads 0, and `irq_o` is 0.
- R2: A running channel with reload value L lowers its count by one each cycle. It sets its flag when it steps at count 0, so flags come L+1 cycles apart, and L = 0 gives an expiry on every cycle.
- R3: Writing the reload register of a running channel leaves the count alone (it keeps falling by one per cycle). The new value is loaded only at the next expiry.
- R4: Writing the control register with run = 1 while the channel is stopped loads the count from the reload register at that edge, which starts a fresh period.
- R5: The halt bit is bit 0 at word address 0. While it is 1, no channel's count changes.
- R6: A channel's flag is set on expiry whether or not its interrupt is enabled. `irq_o[n]` equals flag AND interrupt-enable.
- R7: Writing 1 to bit 0 of a flag register clears the flag, and writing 0 leaves it. If an expiry happens in the same cycle as a clear, the flag stays set.
- R8: With its link bit set, channel 1 steps only in cycles where channel 0 expires. Channels 0, 2 and 3 have no link bit: it reads 0 and has no effect.
- R9: Writing 0 to a channel's control register stops it, and its count then holds its value.
- R10: Channel n (0..3) has four words starting at word address 8+4n: +0 reload, +1 count (read-only), +2 control, +3 flag. The control register has run at bit 0, interrupt-enable at bit 1 and link at bit 2. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 4 | Per-channel interrupt lines |

## Verification
The bench targets a reload value of 0. A design that handled it wrong would stall, or would let a flag clear win over a back-to-back expiry. A reload write landing in the middle of a period would show up as a jump in the count if the design restarted on it. The bench also writes run=1 to a channel that is already running, which must not restart the period. Further cases are halt during a live count, the linked pair (where a channel 1 that stepped every cycle diverges within a few cycles), and a clear in the exact expiry cycle.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  // control register bit positions
  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_IEN  = 1;
  localparam int unsigned CTL_LINK = 2;
  localparam int unsigned CTL_W    = 3;

  // word offsets inside one channel group
  typedef enum logic [1:0] {
    OFS_RELOAD = 2'd0,
    OFS_COUNT  = 2'd1,
    OFS_CTRL   = 2'd2,
    OFS_FLAG   = 2'd3
  } ch_ofs_e;

  // first channel group starts at word 8 (block index 2)
  localparam int unsigned GRP_BASE_BLK = 2;
  localparam int unsigned HALT_ADDR    = 0;
endpackage

// File: rtl/ptimer_rstsync.sv
module ptimer_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
  import ptimer_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter bit          CHAINABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_i,
  input  logic             link_tick_i,
  input  logic             wr_reload_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_ack_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CTL_W-1:0] ctrl_o,
  output logic             flag_o,
  output logic             step_o,
  output logic             expire_o,
  output logic             restart_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             run_q, ien_q, link_q, flag_q, flag_d;
  logic             step, expire, restart, count_ce;

  // next-state logic
  always_comb begin
    restart  = wr_ctrl_i && wdata_i[CTL_RUN] && !run_q;
    step     = run_q && !halt_i && (link_q ? link_tick_i : 1'b1);
    expire   = step && (count_q == '0);
    count_ce = restart || step;
    if (restart || expire) count_d = reload_q;
    else                   count_d = count_q - 1'b1;
    reload_d = wdata_i;
    flag_d   = expire || (flag_q && !(wr_ack_i && wdata_i[0]));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload_i) reload_q <= reload_d;
      if (count_ce)    count_q  <= count_d;
      if (wr_ctrl_i) begin
        run_q <= wdata_i[CTL_RUN];
        ien_q <= wdata_i[CTL_IEN];
      end
      flag_q <= flag_d;
    end
  end

  generate
    if (CHAINABLE) begin : g_link
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         link_q <= 1'b0;
        else if (wr_ctrl_i) link_q <= wdata_i[CTL_LINK];
      end
    end else begin : g_nolink
      assign link_q = 1'b0;
    end
  endgenerate

  assign reload_o  = reload_q;
  assign count_o   = count_q;
  assign ctrl_o    = {link_q, ien_q, run_q};
  assign flag_o    = flag_q;
  assign step_o    = step;
  assign expire_o  = expire;
  assign restart_o = restart;
  assign irq_o     = flag_q && ien_q;
endmodule

// File: rtl/ptimer_rdmux.sv
module ptimer_rdmux
  import ptimer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             halt_i,
  input  logic [N_CH-1:0][CNT_W-1:0]       reload_i,
  input  logic [N_CH-1:0][CNT_W-1:0]       count_i,
  input  logic [N_CH-1:0][CTL_W-1:0]       ctrl_i,
  input  logic [N_CH-1:0]                  flag_i,
  output logic [CNT_W-1:0]                 rdata_o
);
  localparam int unsigned BLK_W = ADDR_W - 2;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(HALT_ADDR)) rdata_o[0] = halt_i;
    for (int n = 0; n < N_CH; n++) begin
      if (addr_i[ADDR_W-1:2] == BLK_W'(GRP_BASE_BLK + n)) begin
        case (ch_ofs_e'(addr_i[1:0]))
          OFS_RELOAD: rdata_o = reload_i[n];
          OFS_COUNT:  rdata_o = count_i[n];
          OFS_CTRL:   rdata_o = CNT_W'(ctrl_i[n]);
          default:    rdata_o = CNT_W'(flag_i[n]);
        endcase
      end
    end
  end
endmodule

// File: rtl/ptimer_bank.sv
module ptimer_bank
  import ptimer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [N_CH-1:0]   irq_o
);
  localparam int unsigned BLK_W = ADDR_W - 2;

  logic                       rst_sync_n;
  logic                       halt_q, halt_d, halt_ce;
  logic [N_CH-1:0][CNT_W-1:0] reload_w, count_w;
  logic [N_CH-1:0][CTL_W-1:0] ctrl_w;
  logic [N_CH-1:0]            flag_w, step_w, expire_w, restart_w;

  ptimer_rstsync u_rstsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // global halt bit
  always_comb begin
    halt_ce = reg_we && (reg_addr == ADDR_W'(HALT_ADDR));
    halt_d  = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  halt_q <= 1'b1;
    else if (halt_ce) halt_q <= halt_d;
  end

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic grp_hit, link_tick;
      assign grp_hit = reg_we && (reg_addr[ADDR_W-1:2] == BLK_W'(GRP_BASE_BLK + g));
      if (g == 1) begin : g_tick
        assign link_tick = expire_w[0];
      end else begin : g_notick
        assign link_tick = 1'b0;
      end

      ptimer_chan #(
        .CNT_W     (CNT_W),
        .CHAINABLE (g == 1)
      ) u_chan (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .halt_i      (halt_q),
        .link_tick_i (link_tick),
        .wr_reload_i (grp_hit && (reg_addr[1:0] == OFS_RELOAD)),
        .wr_ctrl_i   (grp_hit && (reg_addr[1:0] == OFS_CTRL)),
        .wr_ack_i    (grp_hit && (reg_addr[1:0] == OFS_FLAG)),
        .wdata_i     (reg_wdata),
        .reload_o    (reload_w[g]),
        .count_o     (count_w[g]),
        .ctrl_o      (ctrl_w[g]),
        .flag_o      (flag_w[g]),
        .step_o      (step_w[g]),
        .expire_o    (expire_w[g]),
        .restart_o   (restart_w[g]),
        .irq_o       (irq_o[g])
      );
    end
  endgenerate

  ptimer_rdmux #(
    .N_CH   (N_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_rdmux (
    .addr_i   (reg_addr),
    .halt_i   (halt_q),
    .reload_i (reload_w),
    .count_i  (count_w),
    .ctrl_i   (ctrl_w),
    .flag_i   (flag_w),
    .rdata_o  (reg_rdata)
  );
endmodule

// File: rtl/ptimer_bank_chk.sv
module ptimer_bank_chk
  import ptimer_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       halt,
  input logic [N_CH-1:0][CNT_W-1:0] reload,
  input logic [N_CH-1:0][CNT_W-1:0] count,
  input logic [N_CH-1:0][CTL_W-1:0] ctrl,
  input logic [N_CH-1:0]            flag,
  input logic [N_CH-1:0]            step,
  input logic [N_CH-1:0]            expire,
  input logic [N_CH-1:0]            restart,
  input logic [N_CH-1:0]            irq
);
  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_a
      p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step[i] && (count[i] != '0) |=> count[i] == $past(count[i]) - 1'b1);
      p_reload_at_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire[i] |=> count[i] == $past(reload[i]));
      p_restart_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart[i] |=> count[i] == $past(reload[i]));
      p_halt_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !restart[i] |=> $stable(count[i]));
      p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq[i] |-> flag[i]);
      p_flag_on_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire[i] |=> flag[i]);
      p_stopped_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[i][CTL_RUN] && !restart[i] |=> $stable(count[i]));
    end
  endgenerate

  p_linked_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1][CTL_LINK] && !expire[0] |-> !step[1]);
endmodule

bind ptimer_bank ptimer_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .halt    (halt_q),
  .reload  (reload_w),
  .count   (count_w),
  .ctrl    (ctrl_w),
  .flag    (flag_w),
  .step    (step_w),
  .expire  (expire_w),
  .restart (restart_w),
  .irq     (irq_o)
);

// File: tb/ptimer_bank_bench.sv
`timescale 1ns/1ps
module ptimer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_o;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit live    = 1'b0;
  bit done    = 1'b0;

  // reference state
  logic [31:0] m_load [4];
  logic [31:0] m_cnt  [4];
  bit          m_en [4], m_ie [4], m_flag [4];
  bit          m_link1, m_halt;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  ptimer_bank u_ptimer_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic int grp_addr(int n, int ofs);
    return 8 + 4*n + ofs;
  endfunction

  // reference update per clock edge, from the requirements
  always @(posedge clk) begin
    logic [31:0] ncnt [4];
    bit nflag [4];
    bit ex [4];
    bit stp;
    int n;
    if (live) begin
      for (int i = 0; i < 4; i++) begin
        stp = m_en[i] && !m_halt && ((i == 1 && m_link1) ? ex[0] : 1'b1);
        ex[i] = stp && (m_cnt[i] == 0);
        ncnt[i] = !stp ? m_cnt[i] : (m_cnt[i] == 0 ? m_load[i] : m_cnt[i] - 1);
        nflag[i] = ex[i] | m_flag[i];
      end
      if (reg_we) begin
        if (reg_addr == 0) m_halt = reg_wdata[0];
        if (reg_addr >= 8 && reg_addr < 24) begin
          n = (reg_addr >> 2) - 2;
          case (reg_addr[1:0])
            2'd0: m_load[n] = reg_wdata;
            2'd2: begin
              if (reg_wdata[0] && !m_en[n]) ncnt[n] = m_load[n];
              m_en[n] = reg_wdata[0];
              m_ie[n] = reg_wdata[1];
              if (n == 1) m_link1 = reg_wdata[2];
            end
            2'd3: if (reg_wdata[0]) nflag[n] = ex[n];
            default: ;
          endcase
        end
      end
      for (int i = 0; i < 4; i++) begin
        m_cnt[i]  = ncnt[i];
        m_flag[i] = nflag[i];
      end
    end
  end

  function automatic logic [31:0] exp_rd(int a);
    int n;
    if (a == 0) return {31'b0, m_halt};
    if (a < 8 || a >= 24) return '0;
    n = (a >> 2) - 2;
    case (a & 3)
      0: return m_load[n];
      1: return m_cnt[n];
      2: return {29'b0, (n == 1) ? m_link1 : 1'b0, m_ie[n], m_en[n]};
      default: return {31'b0, m_flag[n]};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp, string what);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic rd(int a, output logic [31:0] v);
    reg_addr = 6'(a);
    #0.05;
    v = reg_rdata;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  // compare every mapped word and the irq lines against the reference
  task automatic check_all();
    logic [31:0] v;
    string req;
    for (int a = 0; a < 28; a++) begin
      rd(a, v);
      if (a == 0)                req = "R5";
      else if (a < 8 || a >= 24) req = "R10";
      else case (a & 3)
        0: req = "R3";
        1: req = "R2";
        2: req = "R10";
        default: req = "R7";
      endcase
      chk(req, v, exp_rd(a), $sformatf("addr %0d", a));
    end
    for (int i = 0; i < 4; i++)
      chk("R6", 32'(irq_o[i]), 32'(m_flag[i] && m_ie[i]), $sformatf("irq %0d", i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1;
    int t1, t2, guard;
    void'($urandom(32'd20240517));
    for (int i = 0; i < 4; i++) begin
      m_load[i] = '0; m_cnt[i] = '0; m_en[i] = 0; m_ie[i] = 0; m_flag[i] = 0;
    end
    m_link1 = 0; m_halt = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    live = 1'b1;

    // R1: reset state
    rd(0, v); chk("R1", v, 32'd1, "halt after reset");
    chk("R1", 32'(irq_o), 32'd0, "irq after reset");
    check_all();

    wr(0, 0);
    // R2: period on channel 3 with reload 6 -> 7 cycles
    wr(grp_addr(3, 0), 6);
    wr(grp_addr(3, 2), 3);
    guard = 0;
    while (!irq_o[3] && guard < 50) begin idle(1); guard++; end
    t1 = cyc;
    wr(grp_addr(3, 3), 1);
    guard = 0;
    while (!irq_o[3] && guard < 50) begin idle(1); guard++; end
    t2 = cyc;
    chk("R2", 32'(t2 - t1), 32'd7, "expiry spacing");
    check_all();

    // R2/R7: reload 0 expires every cycle, clear cannot win
    wr(grp_addr(2, 0), 0);
    wr(grp_addr(2, 2), 1);
    idle(3);
    wr(grp_addr(2, 3), 1);
    rd(grp_addr(2, 3), v); chk("R7", v, 32'd1, "flag kept on same-cycle expiry");
    rd(grp_addr(2, 1), v); chk("R2", v, 32'd0, "reload 0 count");
    check_all();

    // R3: reload write mid-period
    wr(grp_addr(2, 2), 0);
    wr(grp_addr(2, 0), 100);
    wr(grp_addr(2, 2), 1);
    idle(5);
    rd(grp_addr(2, 1), c1);
    wr(grp_addr(2, 0), 10);
    rd(grp_addr(2, 1), v); chk("R3", v, c1 - 1, "count after reload write");
    check_all();

    // R4: stop and re-run restarts from the reload value
    idle(3);
    wr(grp_addr(2, 2), 0);
    wr(grp_addr(2, 2), 1);
    rd(grp_addr(2, 1), v); chk("R4", v, 32'd10, "count after restart");
    // run=1 rewritten while running does not restart
    idle(2);
    rd(grp_addr(2, 1), c1);
    wr(grp_addr(2, 2), 1);
    rd(grp_addr(2, 1), v); chk("R4", v, c1 - 1, "no restart while running");

    // R9: writing zero stops and holds
    wr(grp_addr(2, 2), 0);
    rd(grp_addr(2, 1), c1);
    idle(4);
    rd(grp_addr(2, 1), v); chk("R9", v, c1, "stopped count holds");
    check_all();

    // R5: halt freezes every channel
    wr(grp_addr(2, 2), 1);
    wr(0, 1);
    rd(grp_addr(2, 1), c1);
    rd(grp_addr(3, 1), t1[31:0]);
    idle(5);
    rd(grp_addr(2, 1), v); chk("R5", v, c1, "ch2 frozen");
    rd(grp_addr(3, 1), v); chk("R5", v, 32'(t1), "ch3 frozen");
    check_all();
    wr(0, 0);

    // R6: flag without interrupt enable
    wr(grp_addr(3, 2), 1);
    wr(grp_addr(3, 3), 1);
    idle(10);
    rd(grp_addr(3, 3), v); chk("R6", v, 32'd1, "flag set with irq disabled");
    chk("R6", 32'(irq_o[3]), 32'd0, "irq masked");
    wr(grp_addr(3, 2), 3);
    chk("R6", 32'(irq_o[3]), 32'd1, "irq after enable");

    // R7: clear works, zero write does not clear, same-cycle expiry wins
    guard = 0;
    while (m_cnt[3] == 0 && guard < 20) begin idle(1); guard++; end
    wr(grp_addr(3, 3), 1);
    rd(grp_addr(3, 3), v); chk("R7", v, 32'd0, "flag cleared");
    guard = 0;
    while (!m_flag[3] && guard < 20) begin idle(1); guard++; end
    wr(grp_addr(3, 3), 0);
    rd(grp_addr(3, 3), v); chk("R7", v, 32'd1, "zero write keeps flag");
    guard = 0;
    while (m_cnt[3] != 0 && guard < 20) begin idle(1); guard++; end
    wr(grp_addr(3, 3), 1);
    rd(grp_addr(3, 3), v); chk("R7", v, 32'd1, "clear during expiry");
    check_all();

    // R8: link channel 1 to channel 0
    wr(grp_addr(0, 0), 2);
    wr(grp_addr(1, 0), 3);
    wr(grp_addr(1, 2), 5);
    wr(grp_addr(0, 2), 1);
    for (int k = 0; k < 12; k++) begin idle(3); check_all(); end
    wr(grp_addr(2, 2), 7);
    rd(grp_addr(2, 2), v); chk("R8", v, 32'd3, "no link bit on ch2");

    // R10 plus mixed random traffic
    wr(grp_addr(0, 0), 32'hFFFF_FFFF);
    for (int it = 0; it < 400; it++) begin
      int r, n, o;
      logic [31:0] d;
      r = $urandom_range(0, 9);
      if (r < 6) idle($urandom_range(1, 3));
      else if (r == 6) wr(0, ($urandom_range(0, 9) == 0) ? 1 : 0);
      else begin
        n = $urandom_range(0, 3);
        o = $urandom_range(0, 3);
        case (o)
          0: d = $urandom_range(0, 30);
          2: d = $urandom_range(0, 7);
          3: d = $urandom_range(0, 1);
          default: d = $urandom;
        endcase
        wr(grp_addr(n, o), d);
      end
      check_all();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule